// File: doc/BRIEF.md
# Scaled Accumulate-in-Place Datapath

This block is the arithmetic loop of a fixed-function sampled-signal processor. Every clock cycle may carry one instruction. The instruction names two words of a small register file, a scaler code and an ALU code. Both named words are read at once. The word from the first address (the source) goes through a signed power-of-two scaler. The word from the second address (the target) goes to the ALU unscaled. The result replaces the target word. Data are 25-bit two's-complement fractions.

The register file holds 40 words. The remaining source addresses read as zero, except the top address, which reads an external sample input. This lets converted samples enter the loop and lets constants be loaded. Each executed instruction also presents its result and an active-low overflow flag on registered outputs. A program can therefore observe any stored word by passing it through the ALU unchanged.

Top module: `accum_datapath`

## Requirements
- R1: After reset every stored word is zero, `resData` is zero and `ovfN` is 1.
- R2: An executed instruction writes its result into the word at `addrB`. `addrA` and `addrB` are read in the same cycle and may be equal.
- R3: Scaler code c multiplies the source by 2^(2-c). Code 0 shifts left by 2, code 1 shifts left by 1 and code 2 leaves the source unchanged. Codes 3 to 15 are arithmetic right shifts of 1 to 13 bits that keep the sign.
- R4: A left shift that changes the source's value (the bits shifted out differ from the new sign bit) drives `ovfN` to 0. The stored value is the shifted word truncated to 25 bits.
- R5: ALU code 0 gives target+scaled and code 1 gives target-scaled. Both wrap to 25 bits, and a signed overflow drives `ovfN` to 0.
- R6: Code 2 gives the scaled source. Code 3 gives its absolute value. The absolute value of the most negative word (0x1000000) stays 0x1000000 with `ovfN`=0.
- R7: Code 4 gives the bitwise AND of target and scaled source. Code 5 gives the target unchanged and ignores scaler overflow.
- R8: Code 6 gives target+scaled clamped to 0x0FFFFFF or 0x1000000. `ovfN`=0 when it clamps.
- R9: Code 7 writes nothing and leaves `resData` unchanged. It sets `ovfN` to 1.
- R10: Source addresses 40 to 62 read zero and source address 63 reads `sampleIn`. A target address of 40 or more reads zero and suppresses write-back, but the result is still reported.
- R11: While `instValid` is 0, no word, `resData` or `ovfN` changes.
- R12: `resData` and `ovfN` update at the same clock edge that writes the result. The next instruction reads the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction present this cycle |
| addrA | input | 6 | Source (scaled) address |
| addrB | input | 6 | Target address, also write-back address |
| scaleCode | input | 4 | Scaler code |
| aluCode | input | 3 | ALU operation code |
| sampleIn | input | 25 | External sample read at source address 63 |
| resData | output | 25 | Result of the last executed instruction |
| ovfN | output | 1 | Active-low overflow of the last executed instruction |

## Verification
Reads are combinational and the result register and the file update on one edge. So `resData` and `ovfN` are due one clock edge after an instruction is presented, and a stored word is visible to the very next instruction. The bench drives each instruction on a falling edge and lets one rising edge pass. It samples the outputs on the following falling edge. Stored contents are checked by issuing a pass-through instruction and sampling its result one edge later. Idle and no-op cases are checked the same way: an instruction that would have changed the state is followed by a read-back.

// File: rtl/accdp_pkg.sv
package accdp_pkg;
  localparam int SCW = 4;
  localparam int OPW = 3;
  localparam int UNITY_CODE = 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_LOAD   = 3'd2,
    OP_ABS    = 3'd3,
    OP_AND    = 3'd4,
    OP_PASS   = 3'd5,
    OP_SATADD = 3'd6,
    OP_NOP    = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic           exec;
    logic           wrEn;
    logic           useScaled;
    aluOp_e         op;
    logic           shLeft;
    logic [SCW-1:0] shAmt;
  } ctrlStrobe_t;
endpackage

// File: rtl/accdp_ctrl.sv
module accdp_ctrl
  import accdp_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DEPTH = 40
) (
  input  logic           instValid,
  input  logic [AW-1:0]  addrB,
  input  logic [SCW-1:0] scaleCode,
  input  logic [OPW-1:0] aluCode,
  output ctrlStrobe_t    strobe
);
  localparam logic [SCW-1:0] UNITY = SCW'(UNITY_CODE);

  always_comb begin
    strobe.exec      = instValid;
    strobe.op        = aluOp_e'(aluCode);
    strobe.wrEn      = instValid && (strobe.op != OP_NOP) && (int'(addrB) < DEPTH);
    strobe.useScaled = (strobe.op != OP_PASS) && (strobe.op != OP_NOP);
    if (scaleCode < UNITY) begin
      strobe.shLeft = 1'b1;
      strobe.shAmt  = UNITY - scaleCode;
    end else begin
      strobe.shLeft = 1'b0;
      strobe.shAmt  = scaleCode - UNITY;
    end
  end
endmodule

// File: rtl/accdp_dpath.sv
module accdp_dpath
  import accdp_pkg::*;
#(
  parameter int DW    = 25,
  parameter int AW    = 6,
  parameter int DEPTH = 40
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [AW-1:0] addrA,
  input  logic [AW-1:0] addrB,
  input  logic [DW-1:0] sampleIn,
  output logic [DW-1:0] resData,
  output logic          ovfN
);
  localparam logic [AW-1:0] SAMPLE_ADDR = {AW{1'b1}};
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdA, rdB, scaled, back, res;
  logic [DW:0]   sumX, diffX;
  logic          sclOvf, addOvf, subOvf, aluOvf;

  // two read ports
  always_comb begin
    rdA = '0;
    rdB = '0;
    if (int'(addrA) < DEPTH)     rdA = mem[addrA];
    else if (addrA == SAMPLE_ADDR) rdA = sampleIn;
    if (int'(addrB) < DEPTH)     rdB = mem[addrB];
  end

  // scaler
  always_comb begin
    if (strobe.shLeft) begin
      scaled = rdA << strobe.shAmt;
      back   = DW'($signed(scaled) >>> strobe.shAmt);
      sclOvf = (back != rdA);
    end else begin
      scaled = DW'($signed(rdA) >>> strobe.shAmt);
      back   = rdA;
      sclOvf = 1'b0;
    end
  end

  // ALU
  always_comb begin
    sumX   = {rdB[DW-1], rdB} + {scaled[DW-1], scaled};
    diffX  = {rdB[DW-1], rdB} - {scaled[DW-1], scaled};
    addOvf = sumX[DW] ^ sumX[DW-1];
    subOvf = diffX[DW] ^ diffX[DW-1];
    aluOvf = 1'b0;
    unique case (strobe.op)
      OP_ADD:    begin res = sumX[DW-1:0];  aluOvf = addOvf; end
      OP_SUB:    begin res = diffX[DW-1:0]; aluOvf = subOvf; end
      OP_LOAD:   res = scaled;
      OP_ABS:    begin
                   res    = scaled[DW-1] ? (~scaled + 1'b1) : scaled;
                   aluOvf = (scaled == MINV);
                 end
      OP_AND:    res = rdB & scaled;
      OP_PASS:   res = rdB;
      OP_SATADD: begin
                   res    = addOvf ? (sumX[DW] ? MINV : MAXV) : sumX[DW-1:0];
                   aluOvf = addOvf;
                 end
      default:   res = rdB;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData <= '0;
      ovfN    <= 1'b1;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.exec) begin
      if (strobe.op == OP_NOP) begin
        ovfN <= 1'b1;
      end else begin
        resData <= res;
        ovfN    <= !((strobe.useScaled && sclOvf) || aluOvf);
      end
      if (strobe.wrEn) mem[addrB] <= res;
    end
  end

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.exec |=> $stable(resData) && $stable(ovfN));

  assert_nop_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.op == OP_NOP) |=> $stable(resData) && ovfN);

  assert_pass_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.op == OP_PASS) |=> (resData == $past(rdB)) && ovfN);

  assert_abs_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.op == OP_ABS) |=> !resData[DW-1] || !ovfN);

  assert_sat_clamp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.op == OP_SATADD) |=>
      ovfN || resData == MAXV || resData == MINV || $past(sclOvf));
endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accdp_pkg::*;
#(
  parameter int DW    = 25,
  parameter int AW    = 6,
  parameter int DEPTH = 40
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           instValid,
  input  logic [AW-1:0]  addrA,
  input  logic [AW-1:0]  addrB,
  input  logic [SCW-1:0] scaleCode,
  input  logic [OPW-1:0] aluCode,
  input  logic [DW-1:0]  sampleIn,
  output logic [DW-1:0]  resData,
  output logic           ovfN
);
  ctrlStrobe_t strobe;

  accdp_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
    .instValid (instValid),
    .addrB     (addrB),
    .scaleCode (scaleCode),
    .aluCode   (aluCode),
    .strobe    (strobe)
  );

  accdp_dpath #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addrA    (addrA),
    .addrB    (addrB),
    .sampleIn (sampleIn),
    .resData  (resData),
    .ovfN     (ovfN)
  );

  assert_wb_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> instValid && (int'(addrB) < DEPTH));
endmodule

// File: tb/accum_datapath_bench.sv
`timescale 1ns/1ps
module accum_datapath_bench;
  localparam logic [5:0] SMP = 6'd63;
  localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, LOAD = 3'd2, ABSV = 3'd3,
                         ANDV = 3'd4, PASS = 3'd5, SAT = 3'd6, NOP = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [5:0]  addrA = '0, addrB = '0;
  logic [3:0]  scaleCode = 4'd2;
  logic [2:0]  aluCode = NOP;
  logic [24:0] sampleIn = '0;
  logic [24:0] resData;
  logic        ovfN;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  accum_datapath u_accum_datapath (
    .clk(clk), .rstN(rstN), .instValid(instValid), .addrA(addrA), .addrB(addrB),
    .scaleCode(scaleCode), .aluCode(aluCode), .sampleIn(sampleIn),
    .resData(resData), .ovfN(ovfN)
  );

  task automatic chk(input string tag, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%07h expected 0x%07h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [5:0] a, input logic [5:0] b,
                       input logic [3:0] sc, input logic [2:0] op, input logic [24:0] smp);
    @(negedge clk);
    instValid = v; addrA = a; addrB = b; scaleCode = sc; aluCode = op; sampleIn = smp;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic readBack(input string tag, input logic [5:0] b, input logic [24:0] exp);
    issue(1'b1, 6'd40, b, 4'd2, PASS, '0);
    chk(tag, resData, exp);
  endtask

  task automatic put(input logic [5:0] b, input logic [24:0] v);
    issue(1'b1, SMP, b, 4'd2, LOAD, v);
  endtask

  task automatic testReset;
    chk("R1 resData after reset", resData, '0);
    chk("R1 ovfN after reset", {24'd0, ovfN}, 25'd1);
    readBack("R1 word 0 zero", 6'd0, '0);
    readBack("R1 word 39 zero", 6'd39, '0);
  endtask

  task automatic testLoadStore;
    put(6'd3, 25'h0123456);
    chk("R2 load result", resData, 25'h0123456);
    readBack("R12 next instruction sees write", 6'd3, 25'h0123456);
  endtask

  task automatic testScaler;
    issue(1'b1, SMP, 6'd20, 4'd0, LOAD, 25'h0001000);
    chk("R3 x4", resData, 25'h0004000);
    chk("R3 x4 no ovf", {24'd0, ovfN}, 25'd1);
    issue(1'b1, SMP, 6'd20, 4'd1, LOAD, 25'h1FFFFFF);
    chk("R3 x2 negative", resData, 25'h1FFFFFE);
    issue(1'b1, SMP, 6'd20, 4'd3, LOAD, 25'h0000003);
    chk("R3 right 1", resData, 25'h0000001);
    issue(1'b1, SMP, 6'd20, 4'd15, LOAD, 25'h1000000);
    chk("R3 right 13 sign kept", resData, 25'h1FFF800);
  endtask

  task automatic testLeftOvf;
    issue(1'b1, SMP, 6'd21, 4'd1, LOAD, 25'h0C00000);
    chk("R4 left shift ovf flag", {24'd0, ovfN}, 25'd0);
    chk("R4 truncated value", resData, 25'h1800000);
  endtask

  task automatic testAddSub;
    put(6'd1, 25'h0100000);
    issue(1'b1, SMP, 6'd1, 4'd2, ADD, 25'h0000010);
    chk("R5 add", resData, 25'h0100010);
    chk("R5 add no ovf", {24'd0, ovfN}, 25'd1);
    put(6'd2, 25'h0FFFFFF);
    issue(1'b1, SMP, 6'd2, 4'd2, ADD, 25'h0000001);
    chk("R5 add wraps", resData, 25'h1000000);
    chk("R5 add ovf", {24'd0, ovfN}, 25'd0);
    issue(1'b1, SMP, 6'd4, 4'd2, SUB, 25'h0000005);
    chk("R5 sub", resData, 25'h1FFFFFB);
  endtask

  task automatic testDualRead;
    issue(1'b1, 6'd3, 6'd1, 4'd2, ADD, '0);
    chk("R2 two words added", resData, 25'h0223466);
    issue(1'b1, 6'd3, 6'd3, 4'd3, ADD, '0);
    chk("R2 same address", resData, 25'h01B4E81);
    readBack("R2 write-back target", 6'd3, 25'h01B4E81);
  endtask

  task automatic testAbs;
    issue(1'b1, SMP, 6'd22, 4'd2, ABSV, 25'h1FFFFF0);
    chk("R6 abs", resData, 25'h0000010);
    issue(1'b1, SMP, 6'd22, 4'd2, ABSV, 25'h1000000);
    chk("R6 abs min value", resData, 25'h1000000);
    chk("R6 abs min ovf", {24'd0, ovfN}, 25'd0);
  endtask

  task automatic testAndPass;
    put(6'd6, 25'h0F0F0F0);
    issue(1'b1, SMP, 6'd6, 4'd2, ANDV, 25'h0FF00FF);
    chk("R7 and", resData, 25'h0F000F0);
    issue(1'b1, SMP, 6'd6, 4'd0, PASS, 25'h0C00000);
    chk("R7 pass value", resData, 25'h0F000F0);
    chk("R7 pass ignores scaler ovf", {24'd0, ovfN}, 25'd1);
  endtask

  task automatic testSat;
    put(6'd7, 25'h0FFFF00);
    issue(1'b1, SMP, 6'd7, 4'd2, SAT, 25'h0000200);
    chk("R8 clamp high", resData, 25'h0FFFFFF);
    chk("R8 clamp ovf", {24'd0, ovfN}, 25'd0);
    put(6'd8, 25'h1000100);
    issue(1'b1, SMP, 6'd8, 4'd2, SAT, 25'h1FFFE00);
    chk("R8 clamp low", resData, 25'h1000000);
    issue(1'b1, SMP, 6'd9, 4'd2, SAT, 25'h0000005);
    chk("R8 no clamp", resData, 25'h0000005);
    chk("R8 no clamp flag", {24'd0, ovfN}, 25'd1);
  endtask

  task automatic testNop;
    issue(1'b1, SMP, 6'd21, 4'd1, LOAD, 25'h0C00000);
    issue(1'b1, SMP, 6'd9, 4'd0, NOP, 25'h0C00000);
    chk("R9 nop keeps result", resData, 25'h1800000);
    chk("R9 nop clears flag", {24'd0, ovfN}, 25'd1);
    readBack("R9 nop no write", 6'd9, 25'h0000005);
  endtask

  task automatic testAddrRange;
    put(6'd45, 25'h0000777);
    chk("R10 result still reported", resData, 25'h0000777);
    readBack("R10 high target no write", 6'd45, '0);
    put(6'd10, 25'h0000123);
    issue(1'b1, 6'd50, 6'd10, 4'd2, LOAD, 25'h1555555);
    chk("R10 high source reads zero", resData, '0);
  endtask

  task automatic testIdle;
    issue(1'b1, SMP, 6'd21, 4'd1, LOAD, 25'h0C00000);
    issue(1'b0, SMP, 6'd11, 4'd2, LOAD, 25'h0000123);
    chk("R11 idle keeps result", resData, 25'h1800000);
    chk("R11 idle keeps flag", {24'd0, ovfN}, 25'd0);
    readBack("R11 idle no write", 6'd11, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadStore();
    testScaler();
    testLeftOvf();
    testAddSub();
    testDualRead();
    testAbs();
    testAndPass();
    testSat();
    testNop();
    testAddrRange();
    testIdle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule